// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative cache of virtual-to-physical page translations for a memory management unit. Each entry records the address-space identifier it was installed under. A probe can hit only entries whose identifier equals the identifier currently in force, so translations for several processes stay resident together. A context switch then only loads a new identifier, and no entry has to be flushed.

A lookup presents a virtual page number and an access type. In the same cycle the block reports one of three outcomes: a hit, a miss, or a protection fault. With a hit or a fault it also returns the physical frame and the permission bits. A miss only means that a table walk is needed. The walk itself is outside this block, and its result comes back through the fill port. An entry covers either a small page (12-bit offset) or a large page (21-bit offset). A large entry spans 512 small pages, and for it the low 9 bits of the page number are passed through to the frame. Two flush commands are provided: one clears every entry, and the other clears only the entries of one identifier.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid and the current identifier is 0, so every lookup misses.
- R2: A lookup can hit only an entry whose stored identifier equals the current identifier. `ctx_we_i` loads `ctx_asid_i` as the current identifier at the next clock edge. Changing the identifier invalidates no entry.
- R3: While `lookup_req_i` is high, exactly one of `hit_o`, `miss_o` and `fault_o` is high. While it is low, all three are low. A miss is never reported as a fault.
- R4: A small-page entry matches only when all VPN bits are equal. It returns its stored frame unchanged.
- R5: A large-page entry (`fill_huge_i`=1) ignores VPN bits [8:0] when comparing. It returns a frame made of the stored frame bits [PFN_W-1:9] followed by the lookup VPN bits [8:0].
- R6: `flush_all_i` invalidates every entry at the next edge. `flush_asid_i` invalidates only the entries whose identifier equals `flush_asid_id_i`. A flush takes priority over a fill in the same cycle when that fill would also be flushed.
- R7: A fill is written into the lowest-index invalid entry. When every entry is valid, the fill goes to the entry named by a round-robin pointer. That pointer starts at 0 after reset and advances by one, wrapping, after each fill that uses it.
- R8: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. Access type 0 is read, 1 is write, 2 is fetch, and 3 is treated as read. A matching entry that lacks the bit the access needs raises `fault_o` instead of `hit_o`, and still reports its frame and permissions.
- R9: A fill installs the translation under the current identifier. The new entry becomes visible to lookups only after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctx_we_i | input | 1 | Load a new current identifier |
| ctx_asid_i | input | ASID_W | Identifier to load |
| lookup_req_i | input | 1 | Lookup request |
| lookup_vpn_i | input | VPN_W | Virtual page number to translate |
| lookup_acc_i | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| hit_o | output | 1 | Permitted translation found |
| miss_o | output | 1 | No matching entry; a walk is needed |
| fault_o | output | 1 | Matching entry lacks the needed permission |
| pfn_o | output | PFN_W | Physical frame number |
| perm_o | output | 3 | Permission bits of the matching entry |
| fill_i | input | 1 | Install a walk result |
| fill_vpn_i | input | VPN_W | Virtual page number of the fill |
| fill_pfn_i | input | PFN_W | Physical frame of the fill |
| fill_huge_i | input | 1 | Fill maps a large page |
| fill_perm_i | input | 3 | Permission bits of the fill |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_asid_i | input | 1 | Invalidate the entries of one identifier |
| flush_asid_id_i | input | ASID_W | Identifier to flush |

## Verification
The assertions check on every cycle that the lookup outcome is exclusive and is tied to the request. They also check that an identifier change leaves the valid set untouched, that a full flush empties the buffer, that a fill into a non-full buffer adds exactly one valid entry, and that the round-robin pointer steps when it is used. The bench scenarios are needed for everything that depends on the data stored: the frame values returned, the sweep across all 512 sub-pages of a large entry, which entry the replacement evicts, the per-identifier flush, and the permission-to-access mapping for each access type.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_W_BIT = 1;
  localparam int PERM_X = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  function automatic logic [PERM_W-1:0] need_perm(input logic [1:0] acc);
    logic [PERM_W-1:0] m;
    m = '0;
    case (acc)
      ACC_WRITE: m[PERM_W_BIT] = 1'b1;
      ACC_FETCH: m[PERM_X] = 1'b1;
      default:   m[PERM_R] = 1'b1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tlb_cam_cell.sv
module tlb_cam_cell #(
  parameter int VPN_W     = 36,
  parameter int ASID_W    = 12,
  parameter int HUGE_BITS = 9
) (
  input  logic              valid_i,
  input  logic              huge_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  output logic              match_o
);
  logic [VPN_W-1:0] cmp_mask;

  // large pages drop the low VPN bits from the compare
  assign cmp_mask = huge_i ? {{(VPN_W-HUGE_BITS){1'b1}}, {HUGE_BITS{1'b0}}} : '1;
  assign match_o  = valid_i && (asid_i == cur_asid_i) &&
                    (((vpn_i ^ lkp_vpn_i) & cmp_mask) == '0);
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   rr_i,
  output logic [IDX_W-1:0]   victim_o,
  output logic               full_o
);
  assign full_o = &valid_i;

  always_comb begin
    victim_o = rr_i;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) victim_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int VPN_W    = 36,
  parameter int PFN_W    = 28,
  parameter int ASID_W   = 12,
  parameter int PAGE_OFS = 12,
  parameter int HUGE_OFS = 21,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int HUGE_BITS = HUGE_OFS - PAGE_OFS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctx_we_i,
  input  logic [ASID_W-1:0] ctx_asid_i,
  input  logic              lookup_req_i,
  input  logic [VPN_W-1:0]  lookup_vpn_i,
  input  logic [1:0]        lookup_acc_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              fault_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic [PERM_W-1:0] perm_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_huge_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_id_i
);
  logic [ENTRIES-1:0] valid_q, valid_n, match;
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];
  logic [PERM_W-1:0]  e_perm [ENTRIES];
  logic [ENTRIES-1:0] e_huge;
  logic [ASID_W-1:0]  cur_asid_q;
  logic [IDX_W-1:0]   rr_q, victim, sel;
  logic               full, any_match, allowed;
  logic [PERM_W-1:0]  need;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    tlb_cam_cell #(.VPN_W(VPN_W), .ASID_W(ASID_W), .HUGE_BITS(HUGE_BITS)) u_cell (
      .valid_i    (valid_q[g]),
      .huge_i     (e_huge[g]),
      .asid_i     (e_asid[g]),
      .vpn_i      (e_vpn[g]),
      .cur_asid_i (cur_asid_q),
      .lkp_vpn_i  (lookup_vpn_i),
      .match_o    (match[g])
    );
  end

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i  (valid_q),
    .rr_i     (rr_q),
    .victim_o (victim),
    .full_o   (full)
  );

  // lowest index wins if entries overlap
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
  end

  assign any_match = |match;
  assign need      = need_perm(lookup_acc_i);
  assign allowed   = (e_perm[sel] & need) == need;
  assign hit_o     = lookup_req_i && any_match && allowed;
  assign fault_o   = lookup_req_i && any_match && !allowed;
  assign miss_o    = lookup_req_i && !any_match;
  assign perm_o    = any_match ? e_perm[sel] : '0;
  assign pfn_o     = !any_match ? '0 :
                     e_huge[sel] ? {e_pfn[sel][PFN_W-1:HUGE_BITS], lookup_vpn_i[HUGE_BITS-1:0]}
                                 : e_pfn[sel];

  // fill first, then flush filters the result (flush wins)
  always_comb begin
    valid_n = valid_q;
    if (fill_i) valid_n[victim] = 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin
      logic [ASID_W-1:0] a;
      a = (fill_i && victim == IDX_W'(i)) ? cur_asid_q : e_asid[i];
      if (flush_all_i || (flush_asid_i && a == flush_asid_id_i)) valid_n[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      e_huge     <= '0;
      rr_q       <= '0;
      cur_asid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_asid[i] <= '0;
        e_vpn[i]  <= '0;
        e_pfn[i]  <= '0;
        e_perm[i] <= '0;
      end
    end else begin
      valid_q <= valid_n;
      if (ctx_we_i) cur_asid_q <= ctx_asid_i;
      if (fill_i) begin
        e_asid[victim] <= cur_asid_q;
        e_vpn[victim]  <= fill_vpn_i;
        e_pfn[victim]  <= fill_pfn_i;
        e_perm[victim] <= fill_perm_i;
        e_huge[victim] <= fill_huge_i;
        if (full) rr_q <= rr_q + 1'b1;
      end
    end
  end

  assert_outcome_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_req_i |-> $countones({hit_o, miss_o, fault_o}) == 1);

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_req_i |-> !(hit_o || miss_o || fault_o));

  assert_ctx_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_we_i && !fill_i && !flush_all_i && !flush_asid_i) |=> valid_q == $past(valid_q));

  assert_flush_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> valid_q == '0);

  assert_fill_adds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !(&valid_q) && !flush_all_i && !flush_asid_i)
      |=> $countones(valid_q) == $countones($past(valid_q)) + 1);

  assert_rr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && (&valid_q)) |=> rr_q == IDX_W'($past(rr_q) + 1'b1));
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int VPN_W = 36, PFN_W = 28, ASID_W = 12;

  logic clk = 0, rst_n = 0;
  logic ctx_we = 0, lookup_req = 0, fill = 0, fill_huge = 0;
  logic flush_all = 0, flush_asid = 0;
  logic [ASID_W-1:0] ctx_asid = '0, flush_id = '0;
  logic [VPN_W-1:0] lookup_vpn = '0, fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0, pfn;
  logic [1:0] lookup_acc = 0;
  logic [2:0] fill_perm = '0, perm;
  logic hit, miss, fault;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  asid_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctx_we_i(ctx_we), .ctx_asid_i(ctx_asid),
    .lookup_req_i(lookup_req), .lookup_vpn_i(lookup_vpn), .lookup_acc_i(lookup_acc),
    .hit_o(hit), .miss_o(miss), .fault_o(fault), .pfn_o(pfn), .perm_o(perm),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn), .fill_huge_i(fill_huge),
    .fill_perm_i(fill_perm), .flush_all_i(flush_all), .flush_asid_i(flush_asid),
    .flush_asid_id_i(flush_id)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outcome code: {hit,miss,fault}: 3'b100 hit, 3'b010 miss, 3'b001 fault
  task automatic look(input string req, input logic [VPN_W-1:0] v, input logic [1:0] acc,
                      input logic [2:0] exp_o, input logic [PFN_W-1:0] exp_pfn);
    lookup_req = 1; lookup_vpn = v; lookup_acc = acc;
    #2;
    chk(req, {hit, miss, fault}, exp_o);
    if (exp_o != 3'b010) chk(req, pfn, exp_pfn);
    lookup_req = 0;
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                         input logic h, input logic [2:0] pm);
    @(negedge clk);
    fill = 1; fill_vpn = v; fill_pfn = p; fill_huge = h; fill_perm = pm;
    @(negedge clk);
    fill = 0;
  endtask

  task automatic set_ctx(input logic [ASID_W-1:0] a);
    @(negedge clk); ctx_we = 1; ctx_asid = a;
    @(negedge clk); ctx_we = 0;
  endtask

  task automatic do_flush(input logic all, input logic one, input logic [ASID_W-1:0] id);
    @(negedge clk); flush_all = all; flush_asid = one; flush_id = id;
    @(negedge clk); flush_all = 0; flush_asid = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: empty after reset, identifier 0
    for (int i = 0; i < 4; i++) look("R1", VPN_W'(i * 37), 0, 3'b010, 0);
    // R3: no request, no outcome
    lookup_vpn = 0; #2; chk("R3 idle", {hit, miss, fault}, 3'b000);

    set_ctx(5);
    for (int i = 0; i < 16; i++) do_fill(VPN_W'(36'h1000 + i * 7), PFN_W'(28'h300 + i), 0, 3'b111);
    // R4/R9: every small entry hits with its frame; neighbours miss
    for (int i = 0; i < 16; i++) begin
      look("R4 hit", VPN_W'(36'h1000 + i * 7), 0, 3'b100, PFN_W'(28'h300 + i));
      look("R4 near miss", VPN_W'(36'h1001 + i * 7), 0, 3'b010, 0);
    end

    // R7: full buffer, pointer at 0, evicts entry 0 then entry 1
    do_fill(36'h9000, 28'h999, 0, 3'b111);
    look("R7 evict0", 36'h1000, 0, 3'b010, 0);
    look("R7 new", 36'h9000, 0, 3'b100, 28'h999);
    look("R7 keep1", 36'h1007, 0, 3'b100, 28'h301);
    do_fill(36'h9100, 28'h998, 0, 3'b111);
    look("R7 evict1", 36'h1007, 0, 3'b010, 0);
    look("R7 keep2", 36'h100E, 0, 3'b100, 28'h302);

    // R2: identifier filter, no invalidation on switch
    set_ctx(6);
    look("R2 other id", 36'h100E, 0, 3'b010, 0);
    look("R2 other id", 36'h9000, 0, 3'b010, 0);
    set_ctx(5);
    look("R2 back", 36'h100E, 0, 3'b100, 28'h302);
    look("R2 back", 36'h9100, 0, 3'b100, 28'h998);

    // R6: flush all
    do_flush(1, 0, 0);
    for (int i = 2; i < 16; i++) look("R6 all", VPN_W'(36'h1000 + i * 7), 0, 3'b010, 0);
    look("R6 all", 36'h9000, 0, 3'b010, 0);

    // R9: fill visible only after the edge
    @(negedge clk);
    fill = 1; fill_vpn = 36'h40200; fill_pfn = 28'h1200; fill_huge = 1; fill_perm = 3'b111;
    look("R9 before edge", 36'h40200, 0, 3'b010, 0);
    @(negedge clk); fill = 0;
    look("R9 after edge", 36'h40200, 0, 3'b100, 28'h1200);

    // R5: sweep all sub-pages of the large entry
    for (int k = 0; k < 512; k++)
      look("R5 sweep", VPN_W'(36'h40200 + k), 0, 3'b100, PFN_W'(28'h1200 + k));
    look("R5 above", 36'h40400, 0, 3'b010, 0);
    look("R5 below", 36'h401FF, 0, 3'b010, 0);
    do_fill(36'h80255, 28'h2A7F, 1, 3'b111);
    look("R5 merge", 36'h80203, 0, 3'b100, 28'h2A03);

    // R8: permissions by access type
    do_fill(36'h5000, 28'h55, 0, 3'b001);
    do_fill(36'h5001, 28'h56, 0, 3'b110);
    look("R8 read ok", 36'h5000, 0, 3'b100, 28'h55);
    look("R8 write ro", 36'h5000, 1, 3'b001, 28'h55);
    look("R8 fetch nx", 36'h5000, 2, 3'b001, 28'h55);
    look("R8 rsvd as read", 36'h5000, 3, 3'b100, 28'h55);
    look("R8 read none", 36'h5001, 0, 3'b001, 28'h56);
    look("R8 write ok", 36'h5001, 1, 3'b100, 28'h56);
    look("R8 fetch ok", 36'h5001, 2, 3'b100, 28'h56);
    lookup_req = 1; lookup_vpn = 36'h5000; lookup_acc = 1; #2;
    chk("R8 perm on fault", perm, 3'b001);
    lookup_req = 0;

    // R6: flush one identifier
    set_ctx(7);
    do_fill(36'h7000, 28'h70, 0, 3'b111);
    do_flush(0, 1, 5);
    look("R6 id kept", 36'h7000, 0, 3'b100, 28'h70);
    set_ctx(5);
    look("R6 id gone", 36'h5000, 0, 3'b010, 0);
    look("R6 id gone", 36'h40200, 0, 3'b010, 0);
    look("R6 id gone", 36'h80203, 0, 3'b010, 0);

    // R6: flush beats fill in the same cycle
    @(negedge clk);
    fill = 1; fill_vpn = 36'h6000; fill_pfn = 28'h66; fill_huge = 0; fill_perm = 3'b111;
    flush_all = 1;
    @(negedge clk); fill = 0; flush_all = 0;
    look("R6 flush wins", 36'h6000, 0, 3'b010, 0);
    set_ctx(7);
    look("R6 flush wins", 36'h7000, 0, 3'b010, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule